// File: doc/BRIEF.md
# Unified Pointer Aperture Translator

This block sits in front of the translation hardware of a shader memory pipe. It takes one pointer per request and produces a 48-bit virtual address, a path bit and a memory-type tag. The pointer is 64 bits wide, or 32 bits in the narrow mode. A path bit of 0 sends the address to the device page tables and a path bit of 1 sends it to the host page tables. The addressing mode is taken from two per-process control bits and a draw flag, and it decides how the pointer is read. Two programmable windows, each with 64 KB granularity, redirect the request. The device window relocates the pointer by subtracting its base. The alternate window only swaps the memory type.

In the 64-bit modes, a pointer whose upper bits are not a sign extension of bit 47 is flagged as a hole access, unless a window claims it. Requests flow through a single register stage with valid/ready handshakes on both sides. The input is ready whenever the output register is empty or is being drained in the same cycle, so a consumer that always accepts gets one result per cycle. While `out_ready` is low, a held result stays frozen and the input is refused.

Top module: `ptr_aperture_xlate`

## Requirements
- R1: Mode decode. `in_atc_en`=0 selects device-64 mode whatever `in_ptr32` holds. `in_atc_en`=1 with `in_ptr32`=0 selects host-64 mode. `in_atc_en`=1 with `in_ptr32`=1 selects host-32 mode.
- R2: When `in_draw`=1 the request is handled in device-64 mode, whatever the other two mode bits hold.
- R3: A window spans from {hi, 16'h0000} to {hi_limit, 16'hFFFF}, and both ends are inside it. The ports carry only bits [63:16] of each bound.
- R4: A pointer inside the device window gives `out_va` = (pointer − window base)[47:0], `out_path`=0 and `out_mtype`=`def_mtype`.
- R5: A pointer that hits no window gives `out_va` = pointer[47:0] and `def_mtype`. `out_path` is 1 in the host modes and 0 in device-64 mode.
- R6: In the 64-bit modes, `out_hole`=1 exactly when no window is hit and pointer bits [63:47] are neither all zeros nor all ones.
- R7: In host-32 mode, pointer bits [63:32] are ignored (treated as zero), the alternate window is never matched, and `out_hole` is 0.
- R8: A pointer in the alternate window (and not in the device window) takes `alt_mtype` and the default path bit of its mode, and `out_va` = pointer[47:0].
- R9: When a pointer hits both windows, the device window wins. `cfg_err` is then set after the accepting edge and stays set until reset.
- R10: An accepted request (`in_valid && in_ready`) shows `out_valid`=1 after the next edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid && !out_ready`, all outputs hold.
- R11: During and after reset, `out_valid`=0, `cfg_err`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_ptr | input | 64 | Shader pointer |
| in_atc_en | input | 1 | Host-translation enable for this process |
| in_ptr32 | input | 1 | Narrow-pointer select |
| in_draw | input | 1 | Request comes from a draw, forces device-64 mode |
| vm_win_base_hi | input | 48 | Device window base, bits [63:16] |
| vm_win_limit_hi | input | 48 | Device window limit, bits [63:16] |
| alt_win_base_hi | input | 48 | Alternate window base, bits [63:16] |
| alt_win_limit_hi | input | 48 | Alternate window limit, bits [63:16] |
| alt_mtype | input | 2 | Memory type for alternate-window hits |
| def_mtype | input | 2 | Memory type used by all other requests |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_va | output | 48 | Translated virtual address |
| out_path | output | 1 | 1 = host tables, 0 = device tables |
| out_mtype | output | 2 | Memory-type tag |
| out_hole | output | 1 | Pointer lies in the non-canonical hole |
| cfg_err | output | 1 | Sticky: a request hit both windows |

## Verification
A wrong mode decode shows up on the next result as a flipped path bit, a missing or spurious hole flag, or a truncated address. Pointers with garbage upper bits and a window placed in the low 4 GB expose it within one request. An off-by-one window compare only appears at the exact base, base−1, limit and limit+1 addresses, so each of those is sent. A faulty holding register shows up as a changed output or a lost or duplicated result during a stall, and the scoreboard catches that on the very next consumed item.

// File: rtl/upat_pkg.sv
package upat_pkg;
  typedef enum logic [1:0] {
    MODE_VM64 = 2'd0,
    MODE_H64  = 2'd1,
    MODE_H32  = 2'd2
  } mode_e;
endpackage

// File: rtl/upat_mode_dec.sv
module upat_mode_dec
  import upat_pkg::*;
(
  input  logic  atc_en,
  input  logic  ptr32,
  input  logic  draw,
  output mode_e mode
);
  always_comb begin
    if (draw || !atc_en) mode = MODE_VM64;
    else if (ptr32)      mode = MODE_H32;
    else                 mode = MODE_H64;
  end
endmodule

// File: rtl/upat_window.sv
module upat_window #(
  parameter int PTR_W  = 64,
  parameter int GRAN_W = 16,
  localparam int HI_W  = PTR_W - GRAN_W
) (
  input  logic [PTR_W-1:0] addr,
  input  logic [HI_W-1:0]  base_hi,
  input  logic [HI_W-1:0]  limit_hi,
  output logic             hit
);
  logic [PTR_W-1:0] lo_bound, hi_bound;
  assign lo_bound = {base_hi,  {GRAN_W{1'b0}}};
  assign hi_bound = {limit_hi, {GRAN_W{1'b1}}};
  assign hit = (addr >= lo_bound) && (addr <= hi_bound);
endmodule

// File: rtl/upat_canon.sv
module upat_canon #(
  parameter int PTR_W = 64,
  parameter int VA_W  = 48,
  localparam int TOP_W = PTR_W - VA_W + 1
) (
  input  logic [PTR_W-1:0] addr,
  output logic             canonical
);
  logic [TOP_W-1:0] top_bits;
  assign top_bits  = addr[PTR_W-1:VA_W-1];
  assign canonical = (top_bits == '0) || (top_bits == '1);
endmodule

// File: rtl/ptr_aperture_xlate.sv
module ptr_aperture_xlate
  import upat_pkg::*;
#(
  parameter int PTR_W    = 64,
  parameter int VA_W     = 48,
  parameter int NARROW_W = 32,
  parameter int GRAN_W   = 16,
  parameter int MT_W     = 2,
  localparam int HI_W    = PTR_W - GRAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PTR_W-1:0]  in_ptr,
  input  logic              in_atc_en,
  input  logic              in_ptr32,
  input  logic              in_draw,
  input  logic [HI_W-1:0]   vm_win_base_hi,
  input  logic [HI_W-1:0]   vm_win_limit_hi,
  input  logic [HI_W-1:0]   alt_win_base_hi,
  input  logic [HI_W-1:0]   alt_win_limit_hi,
  input  logic [MT_W-1:0]   alt_mtype,
  input  logic [MT_W-1:0]   def_mtype,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VA_W-1:0]   out_va,
  output logic              out_path,
  output logic [MT_W-1:0]   out_mtype,
  output logic              out_hole,
  output logic              cfg_err
);
  mode_e            mode;
  logic [PTR_W-1:0] eff_ptr;
  logic             vm_hit, alt_raw_hit, alt_hit, canonical, acc;
  logic [VA_W-1:0]  vm_base_lo, nx_va;
  logic             nx_path, nx_hole;
  logic [MT_W-1:0]  nx_mtype;

  upat_mode_dec u_mode (
    .atc_en(in_atc_en), .ptr32(in_ptr32), .draw(in_draw), .mode(mode)
  );

  // Narrow mode: upper pointer bits are not part of the address.
  assign eff_ptr = (mode == MODE_H32) ?
                   {{(PTR_W-NARROW_W){1'b0}}, in_ptr[NARROW_W-1:0]} : in_ptr;

  upat_window #(.PTR_W(PTR_W), .GRAN_W(GRAN_W)) u_vm_win (
    .addr(eff_ptr), .base_hi(vm_win_base_hi), .limit_hi(vm_win_limit_hi), .hit(vm_hit)
  );
  upat_window #(.PTR_W(PTR_W), .GRAN_W(GRAN_W)) u_alt_win (
    .addr(eff_ptr), .base_hi(alt_win_base_hi), .limit_hi(alt_win_limit_hi), .hit(alt_raw_hit)
  );
  upat_canon #(.PTR_W(PTR_W), .VA_W(VA_W)) u_canon (
    .addr(eff_ptr), .canonical(canonical)
  );

  assign alt_hit    = alt_raw_hit && (mode != MODE_H32);
  assign vm_base_lo = {vm_win_base_hi[VA_W-GRAN_W-1:0], {GRAN_W{1'b0}}};

  always_comb begin
    nx_va    = eff_ptr[VA_W-1:0];
    nx_path  = (mode != MODE_VM64);
    nx_mtype = def_mtype;
    nx_hole  = 1'b0;
    if (vm_hit) begin
      nx_va   = eff_ptr[VA_W-1:0] - vm_base_lo;
      nx_path = 1'b0;
    end else if (alt_hit) begin
      nx_mtype = alt_mtype;
    end else begin
      nx_hole = (mode != MODE_H32) && !canonical;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_va    <= '0;
      out_path  <= 1'b0;
      out_mtype <= '0;
      out_hole  <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (acc) begin
        out_va    <= nx_va;
        out_path  <= nx_path;
        out_mtype <= nx_mtype;
        out_hole  <= nx_hole;
        if (vm_hit && alt_hit) cfg_err <= 1'b1;
      end
    end
  end

  // R10
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_va) && $stable(out_path)
                                   && $stable(out_mtype) && $stable(out_hole)));
  // R9
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R7
  narrow_no_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == MODE_H32) |=> !out_hole);
  // R4
  vm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && vm_hit) |=> (!out_path && !out_hole));
  // R2
  draw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_draw) |=> !out_path);
endmodule

// File: tb/tb_ptr_aperture_xlate.sv
`timescale 1ns/1ps
module tb_ptr_aperture_xlate;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready, in_atc_en = 0, in_ptr32 = 0, in_draw = 0;
  logic [63:0] in_ptr = '0;
  logic [47:0] vm_b = '0, vm_l = '0, alt_b = '0, alt_l = '0;
  logic [1:0]  alt_mt = 2'b10, def_mt = 2'b01;
  logic        out_valid, out_ready = 1, out_path, out_hole, cfg_err;
  logic [47:0] out_va;
  logic [1:0]  out_mtype;
  int          checks = 0, errors = 0;
  logic [51:0] exp_q[$];
  string       req_q[$];

  always #4 clk = ~clk;

  ptr_aperture_xlate dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr),
    .in_atc_en(in_atc_en), .in_ptr32(in_ptr32), .in_draw(in_draw),
    .vm_win_base_hi(vm_b), .vm_win_limit_hi(vm_l), .alt_win_base_hi(alt_b),
    .alt_win_limit_hi(alt_l), .alt_mtype(alt_mt), .def_mtype(def_mt),
    .out_valid(out_valid), .out_ready(out_ready), .out_va(out_va), .out_path(out_path),
    .out_mtype(out_mtype), .out_hole(out_hole), .cfg_err(cfg_err)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Expected result {hole, mtype, path, va} from the requirement text.
  function automatic logic [51:0] model(input logic [63:0] ptr, input logic atc,
                                        input logic p32, input logic draw);
    int md;
    logic [63:0] p, vb, vl, ab, al;
    logic vh, ah, dp, hole;
    logic [47:0] va;
    logic [1:0] mt;
    md = (draw || !atc) ? 0 : (p32 ? 2 : 1);      // R1 R2
    p  = (md == 2) ? {32'h0, ptr[31:0]} : ptr;   // R7
    vb = {vm_b, 16'h0000};  vl = {vm_l, 16'hFFFF}; // R3
    ab = {alt_b, 16'h0000}; al = {alt_l, 16'hFFFF};
    vh = (p >= vb) && (p <= vl);
    ah = (md != 2) && (p >= ab) && (p <= al);
    dp = (md != 0);
    hole = 1'b0; mt = def_mt; va = p[47:0];
    if (vh) begin va = p[47:0] - vb[47:0]; dp = 1'b0; end  // R4 R9
    else if (ah) mt = alt_mt;                              // R8
    else hole = (md != 2) && !(p[63:47] == '0 || p[63:47] == '1); // R5 R6
    return {hole, mt, dp, va};
  endfunction

  task automatic send(input logic [63:0] p, input logic a, input logic q,
                      input logic d, input string r);
    @(negedge clk);
    in_ptr = p; in_atc_en = a; in_ptr32 = q; in_draw = d; in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(p, a, q, d));
    req_q.push_back(r);
    @(posedge clk); #1 in_valid = 0;
  endtask

  // Scoreboard monitor
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R10 unexpected result", 64'(out_va), 64'hX);
      else begin
        logic [51:0] e;
        string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        chk(r, 64'({out_hole, out_mtype, out_path, out_va}), 64'(e));
      end
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 out_valid", 64'(out_valid), 0);
    chk("R11 cfg_err", 64'(cfg_err), 0);
    chk("R11 in_ready", 64'(in_ready), 1);
    rst_n = 1;
    vm_b  = 48'h0001_0000_0000; vm_l  = 48'h0001_00FF_FFFF;
    alt_b = 48'h0000_7000_0000; alt_l = 48'h0000_7000_0000;

    send(64'h0000_1234_5678_9ABC, 1, 0, 0, "R1 R5 host64 low");
    @(negedge clk); #2 chk("R10 latency", 64'(out_valid), 1);
    send(64'hFFFF_8000_0000_0010, 1, 0, 0, "R6 canonical high");
    send(64'h0002_0000_0000_0000, 1, 0, 0, "R6 hole");
    send(64'h0001_0000_0000_0000, 1, 0, 0, "R3 R4 base");
    send(64'h0001_00FF_FFFF_FFFF, 1, 0, 0, "R3 R4 limit");
    send(64'h0001_0100_0000_0000, 1, 0, 0, "R3 limit+1");
    send(64'h0000_FFFF_FFFF_FFFF, 1, 0, 0, "R3 base-1");
    send(64'h0001_0000_0123_4567, 0, 0, 0, "R4 device64 hit");
    send(64'h0000_0001_2345_6789, 0, 1, 0, "R1 ptr32 ignored");
    send(64'h0000_0001_2345_6789, 1, 1, 1, "R2 draw forced");
    send(64'h0000_7000_0000_8000, 1, 0, 0, "R8 alt host64");
    send(64'h0000_7000_0000_FFFF, 0, 0, 0, "R8 alt device64");
    // Narrow mode windows in the low 4 GB
    vm_b  = 48'h0000_0000_8000; vm_l = 48'h0000_0000_8FFF;
    alt_b = 48'h0000_0000_0004; alt_l = 48'h0000_0000_0004;
    send(64'h1234_5678_0004_0010, 1, 1, 0, "R7 alt ignored");
    send(64'hDEAD_BEEF_8000_0100, 1, 1, 0, "R7 R4 narrow hit");
    send(64'hFFFF_0000_0000_0100, 1, 1, 0, "R7 no hole");
    send(64'h1234_5678_0004_0010, 1, 0, 0, "R6 wide hole");
    wait (exp_q.size() == 0);
    @(negedge clk); #2 chk("R9 cfg_err clear", 64'(cfg_err), 0);
    // Overlap: device window wins
    alt_b = 48'h0000_0000_7000; alt_l = 48'h0000_0000_9000;
    send(64'h0000_0000_8000_0040, 1, 0, 0, "R9 priority");
    @(negedge clk); #2 chk("R9 cfg_err set", 64'(cfg_err), 1);
    alt_b = 48'h0000_7000_0000; alt_l = 48'h0000_7000_0000;
    send(64'h0000_0000_0000_0040, 1, 0, 0, "R5 after overlap");
    repeat (2) @(negedge clk);
    #2 chk("R9 cfg_err sticky", 64'(cfg_err), 1);
    // Stall hold
    @(negedge clk); out_ready = 0;
    send(64'h0000_0000_ABCD_0000, 1, 0, 0, "R10 stalled item");
    repeat (2) @(negedge clk);
    #2 chk("R10 held valid", 64'(out_valid), 1);
    chk("R10 in_ready low", 64'(in_ready), 0);
    held = out_va;
    @(negedge clk); #2 chk("R10 va stable", 64'(out_va), 64'(held));
    out_ready = 1;
    // Burst with back-pressure
    fork
      for (int i = 0; i < 16; i++)
        send({16'(i * 3), 48'h0000_7000_0000 + 48'(i)}, 1, i[0], i[1], "R10 burst");
      for (int k = 0; k < 30; k++) begin
        @(negedge clk); out_ready = (k % 3 != 1);
      end
    join
    @(negedge clk); out_ready = 1;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule